// File: doc/BRIEF.md
# Fractional Feedback Divider Configuration Bank

This block is a byte-wide register bank that sits behind a host serial-port engine. It holds the setting of a fractional feedback divider for a running loop: a 9-bit integer part and a 21-bit fraction part. The host writes the divider one byte at a time into a shadow copy. The live divider that drives the loop changes only when the shadow is complete, and then all 30 bits change together. A partly written divider therefore never reaches the loop, even though the loop keeps running while the host updates it.

The bank also gathers hardware events into sticky status bits. Each status bit has an enable bit in a mask register, and together they drive an active-low interrupt line. A write-protect input blocks every host write except one: the host can still clear sticky status bits, so interrupts can be serviced on a protected bank.

Burst tracking uses a three-state machine:
- `ST_IDLE` is the rest state.
- An accepted write to a divider byte below the top byte moves the machine to `ST_FILL`, where the burst is incomplete.
- An accepted write to the top divider byte moves it from any state to `ST_APPLY`.
- In `ST_APPLY` the live divider is loaded from the shadow. The machine then returns to `ST_IDLE`. If another divider write arrives in that cycle, it goes to `ST_FILL` or `ST_APPLY` instead.
- `ST_FILL` stays in `ST_FILL` until the top byte is written.

Top module: `cfgbank_top`

## Requirements
- R1: After reset, the live divider is 0, the sticky status is 0, the mask is 0 and `irq_n` is high.
- R2: Addresses 0x00 to 0x03 hold the divider as one little-endian 30-bit word. The fraction is bits 20:0 and the integer is bits 29:21. Bits 7:6 of address 0x03 read as 0.
- R3: A write to divider addresses 0x00 to 0x02 changes only the shadow. The live outputs keep their value, and a read of 0x00 to 0x03 returns the live value, not the shadow.
- R4: An accepted write to address 0x03 loads all 30 shadow bits into the live divider in one step. The outputs still show the old value right after the edge that captures the write, and show the new value after the following edge.
- R5: While `wprot` is high, writes to the divider bytes (0x00 to 0x03) and to the mask (0x09) have no effect, and no commit is started.
- R6: Writing 1 to a bit of the status register (0x08) clears that sticky bit, whether or not `wprot` is high. Writing 0 leaves the bit unchanged.
- R7: A high `evt_in` bit sets its sticky bit at the next edge. If a set and a clear of the same bit happen in the same cycle, the set wins.
- R8: `irq_n` is low exactly when some sticky bit and its mask bit are both 1.
- R9: Writes to addresses other than 0x00 to 0x03, 0x08 and 0x09 change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe, one byte per cycle |
| host_addr | input | ADDR_W | Host byte address for read and write |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Combinational read data for `host_addr` |
| wprot | input | 1 | Write protect, active high |
| evt_in | input | NEV | Hardware event pulses that set sticky bits |
| irq_n | output | 1 | Active-low interrupt |
| fb_int | output | INT_W | Live divider integer part |
| fb_frac | output | FRAC_W | Live divider fraction part |

## Verification
The bench checks the commit point of a burst. It samples the outputs between the edge that captures the top byte and the next edge. A design that loads each byte straight into the live divider, or commits a cycle late, would show a half-written or stale value there. Writes under protection are sent to every divider byte and to the mask. A bank that guarded only some of them, or that blocked status clears as well, would leave a stale interrupt or let a protected divider change. Same-cycle set and clear of one status bit, the unused top bits of the last divider byte, and reads of unmapped addresses are also exercised, since an inverted priority or a leaky address decode would show on the read data.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
    // Address of the sticky status register (write 1 to clear)
    localparam int STAT_OFS = 8;
    // Address of the interrupt mask register
    localparam int MASK_OFS = 9;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_APPLY = 2'd2
    } burst_st_e;
endpackage

// File: rtl/cfgbank_div_stage.sv
module cfgbank_div_stage
    import cfgbank_pkg::*;
#(
    parameter int INT_W  = 9,
    parameter int FRAC_W = 21,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [INT_W-1:0]  live_int,
    output logic [FRAC_W-1:0] live_frac,
    output logic              hit,
    output logic [7:0]        rd_byte
);
    localparam int DIV_W  = INT_W + FRAC_W;
    localparam int NBYTES = (DIV_W + 7) / 8;
    localparam int LAST   = NBYTES - 1;
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam int PAD_W  = NBYTES * 8;

    logic [DIV_W-1:0] shad;
    logic [DIV_W-1:0] live_q;
    logic [PAD_W-1:0] live_pad;
    logic [7:0]       rd_arr [NBYTES];
    burst_st_e        st_q, st_d;
    logic             wr_div, wr_last;

    assign hit     = addr < ADDR_W'(NBYTES);
    assign wr_div  = wr_ok && hit;
    assign wr_last = wr_div && (addr == ADDR_W'(LAST));
    assign live_pad = PAD_W'(live_q);

    // One shadow slice per host byte; the top slice may be narrower than 8 bits
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        localparam int LO = b * 8;
        localparam int HI = (LO + 8 > DIV_W) ? DIV_W : LO + 8;
        localparam int BW = HI - LO;
        logic [BW-1:0] byte_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                byte_q <= '0;
            else if (wr_div && (addr == ADDR_W'(b)))
                byte_q <= wdata[BW-1:0];
        end

        assign shad[LO +: BW] = byte_q;
        assign rd_arr[b]      = live_pad[LO +: 8];
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE, ST_FILL: begin
                if (wr_last)
                    st_d = ST_APPLY;
                else if (wr_div)
                    st_d = ST_FILL;
            end
            ST_APPLY: begin
                if (wr_last)
                    st_d = ST_APPLY;
                else if (wr_div)
                    st_d = ST_FILL;
                else
                    st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Output register: the whole word moves in one edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            live_q <= '0;
        else if (st_q == ST_APPLY)
            live_q <= shad;
    end

    assign live_frac = live_q[FRAC_W-1:0];
    assign live_int  = live_q[DIV_W-1:FRAC_W];
    assign rd_byte   = hit ? rd_arr[addr[IDX_W-1:0]] : 8'h00;
endmodule

// File: rtl/cfgbank_irq.sv
module cfgbank_irq #(
    parameter int NEV = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_stb,
    input  logic           mask_wr,
    input  logic [NEV-1:0] wbits,
    input  logic [NEV-1:0] evt,
    output logic [NEV-1:0] sticky_q,
    output logic [NEV-1:0] mask_q,
    output logic           irq_n
);
    logic [NEV-1:0] clr_bits;

    assign clr_bits = clr_stb ? wbits : '0;

    // Set wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sticky_q <= '0;
        else
            sticky_q <= (sticky_q & ~clr_bits) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_wr)
            mask_q <= wbits;
    end

    assign irq_n = ~|(sticky_q & mask_q);
endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
    import cfgbank_pkg::*;
#(
    parameter int INT_W  = 9,
    parameter int FRAC_W = 21,
    parameter int NEV    = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              wprot,
    input  logic [NEV-1:0]    evt_in,
    output logic              irq_n,
    output logic [INT_W-1:0]  fb_int,
    output logic [FRAC_W-1:0] fb_frac
);
    logic           wr_ok;
    logic           div_hit;
    logic [7:0]     div_rd;
    logic           at_stat, at_mask;
    logic [NEV-1:0] sticky_q, mask_q;

    assign wr_ok   = host_we && !wprot;
    assign at_stat = host_addr == ADDR_W'(STAT_OFS);
    assign at_mask = host_addr == ADDR_W'(MASK_OFS);

    cfgbank_div_stage #(
        .INT_W (INT_W),
        .FRAC_W(FRAC_W),
        .ADDR_W(ADDR_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ok    (wr_ok),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .live_int (fb_int),
        .live_frac(fb_frac),
        .hit      (div_hit),
        .rd_byte  (div_rd)
    );

    // Status clears ignore write protect
    cfgbank_irq #(
        .NEV(NEV)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_stb (host_we && at_stat),
        .mask_wr (wr_ok && at_mask),
        .wbits   (host_wdata[NEV-1:0]),
        .evt     (evt_in),
        .sticky_q(sticky_q),
        .mask_q  (mask_q),
        .irq_n   (irq_n)
    );

    always_comb begin
        host_rdata = 8'h00;
        if (div_hit)
            host_rdata = div_rd;
        else if (at_stat)
            host_rdata = 8'(sticky_q);
        else if (at_mask)
            host_rdata = 8'(mask_q);
    end
endmodule

// File: rtl/cfgbank_chk.sv
module cfgbank_chk
    import cfgbank_pkg::*;
#(
    parameter int INT_W  = 9,
    parameter int FRAC_W = 21,
    parameter int NEV    = 8,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic              wp,
    input logic [NEV-1:0]    evt,
    input logic              irq_n,
    input logic [INT_W-1:0]  div_int,
    input logic [FRAC_W-1:0] div_frac,
    input logic [7:0]        rdata,
    input logic [NEV-1:0]    sticky,
    input logic [NEV-1:0]    mask
);
    localparam int NBYTES = (INT_W + FRAC_W + 7) / 8;
    localparam int LAST   = NBYTES - 1;

    // R5: a blocked cycle cannot lead to a divider change
    p_wp_div_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wp) |=> $stable({div_int, div_frac}));

    // R5: mask is frozen under write protect
    p_mask_wp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wp |=> $stable(mask));

    // R4: the live divider moves only after an accepted top-byte write
    p_commit_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({div_int, div_frac}) |->
            $past(we && !wp && (addr == ADDR_W'(LAST)), 2));

    // R7: an event sets its sticky bit
    p_sticky_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((sticky & $past(evt)) == $past(evt)));

    // R6: sticky bits fall only through a host write
    p_sticky_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ((sticky & $past(sticky)) == $past(sticky)));

    // R8: an active interrupt holds until the host writes
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !we) |=> !irq_n);

    // R9: unmapped reads return zero
    p_unmapped_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr > ADDR_W'(LAST)) && (addr != ADDR_W'(STAT_OFS)) &&
         (addr != ADDR_W'(MASK_OFS))) |-> (rdata == 8'h00));
endmodule

bind cfgbank_top cfgbank_chk #(
    .INT_W (INT_W),
    .FRAC_W(FRAC_W),
    .NEV   (NEV),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (host_we),
    .addr    (host_addr),
    .wp      (wprot),
    .evt     (evt_in),
    .irq_n   (irq_n),
    .div_int (fb_int),
    .div_frac(fb_frac),
    .rdata   (host_rdata),
    .sticky  (sticky_q),
    .mask    (mask_q)
);

// File: tb/cfgbank_top_tb.sv
`timescale 1ns/1ps
module cfgbank_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic [7:0] host_addr = 8'h00;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       wprot = 1'b0;
    logic [7:0] evt_in = 8'h00;
    logic       irq_n;
    logic [8:0] fb_int;
    logic [20:0] fb_frac;

    int nchk = 0;
    int nfail = 0;

    // Reference model
    logic [31:0] m_shad = '0;
    logic [29:0] m_live = '0;
    logic        m_pend = 1'b0;
    logic [7:0]  m_sticky = '0;
    logic [7:0]  m_mask = '0;

    always #2 clk = ~clk;

    cfgbank_top u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .wprot(wprot),
        .evt_in(evt_in), .irq_n(irq_n), .fb_int(fb_int), .fb_frac(fb_frac)
    );

    function automatic logic [7:0] m_read(input logic [7:0] a);
        logic [31:0] pad;
        pad = {2'b00, m_live};
        if (a < 8'd4)       return pad[a*8 +: 8];
        else if (a == 8'd8) return m_sticky;
        else if (a == 8'd9) return m_mask;
        else                return 8'h00;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    // One bus cycle: starts and ends at a falling edge
    task automatic step(input logic w, input logic [7:0] a, input logic [7:0] d,
                        input logic p, input logic [7:0] e, input string tag);
        logic [7:0] clr;
        host_we = w; host_addr = a; host_wdata = d; wprot = p; evt_in = e;
        @(posedge clk);
        if (m_pend) m_live = m_shad[29:0];
        m_pend = 1'b0;
        if (w && !p && a < 8'd4) begin
            m_shad[a*8 +: 8] = d;
            m_shad[31:30] = 2'b00;
            if (a == 8'd3) m_pend = 1'b1;
        end
        if (w && !p && a == 8'd9) m_mask = d;
        clr = (w && a == 8'd8) ? d : 8'h00;
        m_sticky = (m_sticky & ~clr) | e;
        @(negedge clk);
        chk(tag, "divider", {2'b00, fb_int, fb_frac}, {2'b00, m_live});
        chk(tag, "irq_n", {31'd0, irq_n}, {31'd0, ~|(m_sticky & m_mask)});
        chk(tag, "rdata", {24'd0, host_rdata}, {24'd0, m_read(a)});
    endtask

    task automatic idle(input logic [7:0] a, input string tag);
        step(1'b0, a, 8'h00, 1'b0, 8'h00, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        idle(8'h00, "R1"); idle(8'h01, "R1"); idle(8'h02, "R1");
        idle(8'h03, "R1"); idle(8'h08, "R1"); idle(8'h09, "R1");

        // R2: full burst, top bits of byte 3 dropped
        step(1'b1, 8'h00, 8'h11, 1'b0, 8'h00, "R2");
        step(1'b1, 8'h01, 8'h22, 1'b0, 8'h00, "R2");
        step(1'b1, 8'h02, 8'h33, 1'b0, 8'h00, "R2");
        step(1'b1, 8'h03, 8'hFF, 1'b0, 8'h00, "R2");
        idle(8'h03, "R2");
        chk("R2", "int field", {23'd0, fb_int}, {23'd0, 9'h1F9});
        chk("R2", "frac field", {11'd0, fb_frac}, {11'd0, 21'h132211});

        // R3: partial burst leaves live value
        step(1'b1, 8'h00, 8'hAA, 1'b0, 8'h00, "R3");
        step(1'b1, 8'h01, 8'hBB, 1'b0, 8'h00, "R3");
        idle(8'h00, "R3");
        idle(8'h01, "R3");

        // R4: commit is one edge after the top-byte write, all bits at once
        step(1'b1, 8'h03, 8'h01, 1'b0, 8'h00, "R4");
        chk("R4", "old before apply", {2'b00, fb_int, fb_frac}, 32'h3F332211);
        idle(8'h00, "R4");
        chk("R4", "new after apply", {2'b00, fb_int, fb_frac}, 32'h0133BBAA);

        // R5: protected writes to every divider byte and the mask
        step(1'b1, 8'h00, 8'h55, 1'b1, 8'h00, "R5");
        step(1'b1, 8'h01, 8'h55, 1'b1, 8'h00, "R5");
        step(1'b1, 8'h02, 8'h55, 1'b1, 8'h00, "R5");
        step(1'b1, 8'h03, 8'h15, 1'b1, 8'h00, "R5");
        step(1'b1, 8'h09, 8'hFF, 1'b1, 8'h00, "R5");
        idle(8'h09, "R5");
        idle(8'h00, "R5");

        // R6 / R7: clear under protect, set beats clear
        step(1'b0, 8'h08, 8'h00, 1'b0, 8'h05, "R7");
        step(1'b1, 8'h08, 8'h01, 1'b1, 8'h00, "R6");
        step(1'b1, 8'h08, 8'h00, 1'b1, 8'h00, "R6");
        step(1'b1, 8'h08, 8'h04, 1'b0, 8'h04, "R7");
        idle(8'h08, "R7");

        // R8: interrupt gating by mask
        step(1'b1, 8'h09, 8'h04, 1'b0, 8'h00, "R8");
        chk("R8", "irq low", {31'd0, irq_n}, 32'd0);
        step(1'b0, 8'h08, 8'h00, 1'b0, 8'h02, "R8");
        step(1'b1, 8'h08, 8'h04, 1'b0, 8'h00, "R8");
        chk("R8", "irq high", {31'd0, irq_n}, 32'd1);
        step(1'b1, 8'h08, 8'hFF, 1'b0, 8'h00, "R8");

        // R9: unmapped space
        step(1'b1, 8'h20, 8'hFF, 1'b0, 8'h00, "R9");
        step(1'b1, 8'h0A, 8'hFF, 1'b0, 8'h00, "R9");
        for (int a = 4; a < 8; a++) idle(8'(a), "R9");
        idle(8'hFF, "R9");
        idle(8'h09, "R9");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a;
            int sel;
            sel = int'($urandom_range(0, 7));
            case (sel)
                0, 1, 2, 3: a = 8'(sel);
                4: a = 8'h08;
                5: a = 8'h09;
                6: a = 8'($urandom_range(10, 255));
                default: a = 8'h03;
            endcase
            step($urandom_range(0, 3) != 0, a, 8'($urandom()),
                 $urandom_range(0, 3) == 0,
                 ($urandom_range(0, 3) == 0) ? 8'($urandom()) : 8'h00, "RND");
        end

        idle(8'h00, "RND");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule